// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Serial Bus

This block is a target on an SMBus/I2C-style two-wire bus. It gives a host access to a small bank of 8-bit configuration registers using indexed block transfers. Every transfer opens with the write-direction address byte and a starting register index. To write, the host then sends a byte count and that many data bytes, which land in consecutive registers. To read, the host issues a repeated start with the read-direction address byte. The target then returns a count byte and the register contents starting at the index.

The count byte sent back on a read is the value currently held in a dedicated count register inside the register bank (index `CNT_IDX`). The host therefore writes that register first to choose how many bytes it expects. The host acknowledges each byte it receives and sends NACK on the last one.

SCL and SDA are oversampled on a system clock through two-flop synchronizers. The register bank itself sits outside the block, on a simple write-strobe and combinational-read port. The target never holds SCL low.

Top module: `smb_idx_target`

## Requirements
- R1: After start, the address byte 0xDC (`WR_BYTE`), an index byte N and a count byte X are each acknowledged. The next X data bytes are each acknowledged, and each is written with a single-cycle strobe to index N, N+1, ..., in that order.
- R2: Start, 0xDC, index N, repeated start, 0xDD (`RD_BYTE`): all address and index bytes are acknowledged. The target then sends, MSB first, the value of register `CNT_IDX`, followed by the registers at N, N+1, ... for as long as the host acknowledges.
- R3: An address byte other than 0xDC or 0xDD is not acknowledged. Every later byte is also left unacknowledged, and nothing is written, until the next start.
- R4: A write data byte whose index is at or above `NUM_REGS` is acknowledged, but it produces no write strobe.
- R5: A read from an index at or above `NUM_REGS` returns 0x00, whatever the register port returns.
- R6: Write data bytes beyond the count X are acknowledged but discarded.
- R7: After the host NACKs a read byte, the target leaves SDA released for every further SCL clock until a start or stop.
- R8: A stop or a start in the middle of a transfer ends it. Bytes written before that point keep their values, and a transfer that follows a start works normally.
- R9: The target changes SDA only while SCL is low, and it holds an ACK low across the whole SCL high period.
- R10: While in reset, and after reset, SDA and SCL are released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | SCL pull-low enable; always 0 |
| sda_oe_o | output | 1 | SDA pull-low enable |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_idx_o | output | 8 | Register index for write or read |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for `reg_idx_o`, combinational |

## Verification
The bench builds the block with `NUM_REGS` = 12 and the count register at index 8. This makes it practical to sweep every starting index from 0 to 13 with block lengths of 1, 2 and 3. Those sweeps run transfers off the end of the implemented bank and over the count register itself, and each write is read back through the bus. The small bank also keeps the count register's effect on read length short. Directed transfers cover the unknown address, surplus data bytes, host NACK, and aborts by stop and by repeated start.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_TXACK
  } eng_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_CNT,
    K_DATA
  } byte_kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_prev, sda_prev;

  // bus idles high: reset to 1 so no edge is seen on release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff   <= 2'b11;
      sda_ff   <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[0], scl_i};
      sda_ff   <= {sda_ff[0], sda_i};
      scl_prev <= scl_ff[1];
      sda_prev <= sda_ff[1];
    end
  end

  assign scl_o   = scl_ff[1];
  assign sda_o   = sda_ff[1];
  assign rise_o  = scl_ff[1] & ~scl_prev;
  assign fall_o  = ~scl_ff[1] & scl_prev;
  assign start_o = scl_ff[1] & scl_prev & sda_prev & ~sda_ff[1];
  assign stop_o  = scl_ff[1] & scl_prev & ~sda_prev & sda_ff[1];
endmodule

// File: rtl/smb_blk_engine.sv
module smb_blk_engine
  import smb_blk_pkg::*;
#(
  parameter logic [7:0] WR_BYTE  = 8'hDC,
  parameter logic [7:0] RD_BYTE  = 8'hDD,
  parameter int         NUM_REGS = 16,
  parameter int         CNT_IDX  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       sda_oe_o,
  output logic       reg_we_o,
  output logic [7:0] reg_idx_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);
  localparam logic [8:0] NUM_L = 9'(NUM_REGS);
  localparam logic [7:0] CNT_L = 8'(CNT_IDX);

  eng_state_e state_q;
  byte_kind_e kind_q;
  logic [7:0] sh_q, idx_q, rem_q, widx_q, wdata_q;
  logic [3:0] bit_q;
  logic       oe_q, we_q, go_tx_q, first_q, hack_q;
  logic [7:0] tx_byte;
  logic       idx_ok;

  assign idx_ok    = {1'b0, idx_q} < NUM_L;
  assign reg_idx_o = we_q ? widx_q : (first_q ? CNT_L : idx_q);
  assign tx_byte   = first_q ? reg_rdata_i : (idx_ok ? reg_rdata_i : 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_ADDR;
      sh_q    <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      widx_q  <= '0;
      wdata_q <= '0;
      bit_q   <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      go_tx_q <= 1'b0;
      first_q <= 1'b0;
      hack_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (start_i) begin
        state_q <= S_RX;
        kind_q  <= K_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
        first_q <= 1'b0;
      end else if (stop_i) begin
        state_q <= S_IDLE;
        oe_q    <= 1'b0;
        first_q <= 1'b0;
      end else begin
        unique case (state_q)
          S_RX: begin
            if (rise_i && bit_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (fall_i && bit_q == 4'd8) begin
              bit_q   <= '0;
              go_tx_q <= 1'b0;
              state_q <= S_ACK;
              oe_q    <= 1'b1;
              unique case (kind_q)
                K_ADDR: begin
                  if (sh_q == WR_BYTE) begin
                    kind_q <= K_IDX;
                  end else if (sh_q == RD_BYTE) begin
                    go_tx_q <= 1'b1;
                    first_q <= 1'b1;
                  end else begin
                    state_q <= S_IDLE;
                    oe_q    <= 1'b0;
                  end
                end
                K_IDX: begin
                  idx_q  <= sh_q;
                  kind_q <= K_CNT;
                end
                K_CNT: begin
                  rem_q  <= sh_q;
                  kind_q <= K_DATA;
                end
                K_DATA: begin
                  if (rem_q != 8'd0) begin
                    rem_q   <= rem_q - 8'd1;
                    idx_q   <= idx_q + 8'd1;
                    we_q    <= idx_ok;
                    widx_q  <= idx_q;
                    wdata_q <= sh_q;
                  end
                end
                default: ;
              endcase
            end
          end
          S_ACK: begin
            if (fall_i) begin
              if (go_tx_q) begin
                sh_q    <= tx_byte;
                oe_q    <= ~tx_byte[7];
                bit_q   <= 4'd1;
                state_q <= S_TX;
                first_q <= 1'b0;
                if (!first_q) idx_q <= idx_q + 8'd1;
              end else begin
                oe_q    <= 1'b0;
                state_q <= S_RX;
              end
            end
          end
          S_TX: begin
            if (fall_i) begin
              if (bit_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= S_TXACK;
              end else begin
                oe_q  <= ~sh_q[6];
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 4'd1;
              end
            end
          end
          S_TXACK: begin
            if (rise_i) hack_q <= ~sda_i;
            if (fall_i) begin
              if (hack_q) begin
                sh_q    <= tx_byte;
                oe_q    <= ~tx_byte[7];
                bit_q   <= 4'd1;
                state_q <= S_TX;
                idx_q   <= idx_q + 8'd1;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_i); // R9
  AST_ACK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ACK && oe_q && rise_i) |=> oe_q); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !oe_q); // R7
  AST_WE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> ({1'b0, reg_idx_o} < NUM_L)); // R4
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R1
  AST_STOP_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == S_IDLE)); // R8
  AST_START_RESYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == S_RX && kind_q == K_ADDR && bit_q == 4'd0)); // R8
endmodule

// File: rtl/smb_idx_target.sv
module smb_idx_target #(
  parameter logic [7:0] WR_BYTE  = 8'hDC,
  parameter logic [7:0] RD_BYTE  = 8'hDD,
  parameter int         NUM_REGS = 16,
  parameter int         CNT_IDX  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       reg_we_o,
  output logic [7:0] reg_idx_o,
  output logic [7:0] reg_wdata_o,
  input  logic [7:0] reg_rdata_i
);
  logic scl_s, sda_s, rise, fall, start, stop;

  smb_line_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .scl_o   (scl_s),
    .sda_o   (sda_s),
    .rise_o  (rise),
    .fall_o  (fall),
    .start_o (start),
    .stop_o  (stop)
  );

  smb_blk_engine #(
    .WR_BYTE  (WR_BYTE),
    .RD_BYTE  (RD_BYTE),
    .NUM_REGS (NUM_REGS),
    .CNT_IDX  (CNT_IDX)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_s),
    .sda_i       (sda_s),
    .rise_i      (rise),
    .fall_i      (fall),
    .start_i     (start),
    .stop_i      (stop),
    .sda_oe_o    (sda_oe_o),
    .reg_we_o    (reg_we_o),
    .reg_idx_o   (reg_idx_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_rdata_i (reg_rdata_i)
  );

  assign scl_oe_o = 1'b0; // no clock stretching
endmodule

// File: tb/smb_idx_target_bench.sv
`timescale 1ns/1ps
module smb_idx_target_bench;
  localparam int NUM  = 12;
  localparam int CIDX = 8;
  localparam int P    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_h = 1'b1, sda_h = 1'b1;
  logic scl_oe, sda_oe, we;
  logic [7:0] ridx, wdata, rdata;
  logic scl_line, sda_line;
  assign scl_line = scl_h & ~scl_oe;
  assign sda_line = sda_h & ~sda_oe;

  logic [7:0] rf [NUM];
  logic [7:0] exp_rf [NUM];
  int we_cnt = 0, we_bad = 0;
  int n_chk = 0, n_fail = 0;
  int cur_cnt = 0;

  assign rdata = (int'(ridx) < NUM) ? rf[ridx] : 8'hA5;

  always @(posedge clk) begin
    if (we) begin
      we_cnt <= we_cnt + 1;
      if (int'(ridx) < NUM) rf[ridx] <= wdata;
      else we_bad <= we_bad + 1;
    end
  end

  smb_idx_target #(.NUM_REGS(NUM), .CNT_IDX(CIDX)) u_smb_idx_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_we_o(we),
    .reg_idx_o(ridx), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic finish_all();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wait_p();
    repeat (P) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wait_p(); sda_h = b; wait_p(); scl_h = 1'b1; wait_p(); wait_p(); scl_h = 1'b0;
  endtask

  task automatic bit_in(output logic b, output logic st);
    sda_h = 1'b1; wait_p(); wait_p(); scl_h = 1'b1; wait_p();
    b = sda_line; wait_p(); st = (sda_line == b); scl_h = 1'b0;
  endtask

  task automatic send_start();
    sda_h = 1'b1; wait_p(); scl_h = 1'b1; wait_p(); sda_h = 1'b0; wait_p(); scl_h = 1'b0;
  endtask

  task automatic send_stop();
    sda_h = 1'b0; wait_p(); scl_h = 1'b1; wait_p(); sda_h = 1'b1; wait_p(); wait_p();
  endtask

  task automatic byte_out(input logic [7:0] v, output logic ack);
    logic b, st;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(b, st);
    ack = ~b;
    if (!b) check(st, "R9 ack held through SCL high", int'(st), 1);
  endtask

  task automatic byte_in(output logic [7:0] v, input logic nack);
    logic b, st;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      bit_in(b, st);
      v = {v[6:0], b};
    end
    bit_out(nack);
  endtask

  function automatic logic [7:0] pat(input int j, input int seed);
    if (j == CIDX) return 8'(cur_cnt);
    return 8'(j * 37 + seed * 11 + 5);
  endfunction

  task automatic cmp_bank(input string tag);
    int bad = 0;
    repeat (4) @(negedge clk);
    for (int j = 0; j < NUM; j++) if (rf[j] !== exp_rf[j]) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic wr_block(input int idx, input int cnt, input int seed);
    logic a;
    logic [7:0] v;
    send_start();
    byte_out(8'hDC, a); check(a, "R1 write address ack", int'(a), 1);
    byte_out(8'(idx), a); check(a, "R1 index ack", int'(a), 1);
    byte_out(8'(cnt), a); check(a, "R1 count ack", int'(a), 1);
    for (int k = 0; k < cnt; k++) begin
      v = pat(idx + k, seed);
      byte_out(v, a);
      check(a, (idx + k < NUM) ? "R1 data ack" : "R4 out-of-range data ack", int'(a), 1);
      if (idx + k < NUM) exp_rf[idx + k] = v;
    end
    send_stop();
    cmp_bank("R1 bank contents after write");
  endtask

  task automatic rd_block(input int idx);
    logic a;
    logic [7:0] v, e;
    int n;
    send_start();
    byte_out(8'hDC, a); check(a, "R2 address ack", int'(a), 1);
    byte_out(8'(idx), a); check(a, "R2 index ack", int'(a), 1);
    send_start();
    byte_out(8'hDD, a); check(a, "R2 read address ack", int'(a), 1);
    n = int'(exp_rf[CIDX]);
    byte_in(v, n == 0);
    check(v == exp_rf[CIDX], "R2 count byte", int'(v), int'(exp_rf[CIDX]));
    for (int k = 0; k < n; k++) begin
      byte_in(v, k == n - 1);
      e = (idx + k < NUM) ? exp_rf[idx + k] : 8'h00;
      check(v == e, (idx + k < NUM) ? "R2 read data" : "R5 unimplemented reads zero",
            int'(v), int'(e));
    end
    send_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_all();
  end

  initial begin
    logic a, b, st;
    logic [7:0] v;
    int w0, ones;
    for (int j = 0; j < NUM; j++) begin
      rf[j] = 8'h00;
      exp_rf[j] = 8'h00;
    end
    repeat (5) @(negedge clk);
    check(!sda_oe && !scl_oe && !we, "R10 outputs in reset", {29'd0, sda_oe, scl_oe, we}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!sda_oe && !scl_oe && !we, "R10 outputs after reset", {29'd0, sda_oe, scl_oe, we}, 0);

    // sweep start index and block length
    for (int c = 1; c <= 3; c++) begin
      cur_cnt = c;
      wr_block(CIDX, 1, 0);
      for (int i = 0; i < NUM + 2; i++) begin
        wr_block(i, c, i + c);
        rd_block(i);
      end
    end
    check(we_bad == 0, "R4 no strobe at or above NUM_REGS", we_bad, 0);

    // unknown address
    w0 = we_cnt;
    send_start();
    byte_out(8'hA0, a); check(!a, "R3 unknown address nack", int'(a), 0);
    byte_out(8'hDC, a); check(!a, "R3 ignored until start", int'(a), 0);
    byte_out(8'h00, a); check(!a, "R3 ignored until start", int'(a), 0);
    send_stop();
    repeat (4) @(negedge clk);
    check(we_cnt == w0, "R3 no write after unknown address", we_cnt - w0, 0);

    // surplus data beyond count
    send_start();
    byte_out(8'hDC, a); byte_out(8'd2, a); byte_out(8'd1, a);
    byte_out(8'h11, a); check(a, "R6 counted byte ack", int'(a), 1);
    byte_out(8'h22, a); check(a, "R6 surplus byte ack", int'(a), 1);
    byte_out(8'h33, a); check(a, "R6 surplus byte ack", int'(a), 1);
    send_stop();
    exp_rf[2] = 8'h11;
    cmp_bank("R6 surplus bytes discarded");

    // host NACK then keeps clocking
    send_start();
    byte_out(8'hDC, a); byte_out(8'd0, a);
    send_start();
    byte_out(8'hDD, a);
    byte_in(v, 1'b1);
    check(v == exp_rf[CIDX], "R2 count byte before nack", int'(v), int'(exp_rf[CIDX]));
    ones = 0;
    for (int k = 0; k < 18; k++) begin
      bit_in(b, st);
      if (b) ones++;
    end
    check(ones == 18, "R7 SDA released after nack", ones, 18);
    send_stop();
    rd_block(0);

    // abort by stop
    send_start();
    byte_out(8'hDC, a); byte_out(8'd4, a); byte_out(8'd3, a);
    byte_out(8'h5A, a);
    send_stop();
    exp_rf[4] = 8'h5A;
    cmp_bank("R8 stop abort keeps written bytes");

    // abort by repeated start, then new transfer
    send_start();
    byte_out(8'hDC, a); byte_out(8'd6, a); byte_out(8'd2, a);
    byte_out(8'h6B, a);
    send_start();
    byte_out(8'hDC, a); check(a, "R8 address ack after restart", int'(a), 1);
    byte_out(8'd7, a); byte_out(8'd1, a);
    byte_out(8'h7C, a); check(a, "R8 data ack after restart", int'(a), 1);
    send_stop();
    exp_rf[6] = 8'h6B;
    exp_rf[7] = 8'h7C;
    cmp_bank("R8 restart abort keeps written bytes");
    rd_block(5);

    finish_all();
  end
endmodule